// File: doc/BRIEF.md
# Bidirectional Strobed Bus Port

This block is one eight-bit data port that both sends and receives over a single shared set of bus pins. Handshaking controls both directions. A peripheral pushes a byte in by pulsing an active-low strobe. The byte is captured in a receive latch on the strobe's rising edge, and a receive-full flag tells the CPU that a byte is waiting. The CPU pushes a byte out by writing a separate transmit latch. This drives an active-low transmit-full flag. The peripheral takes the byte by pulling its active-low acknowledge low. Only while acknowledge is low does the port drive the bus; at all other times the pins float.

The two latches are independent, so the port can hold a pending transmit and a fresh receive at the same time. Two interrupt-enable bits gate the two sources of one shared interrupt request:

- the receive side raises it while a byte is waiting;
- the transmit side raises it once a byte has been taken and the acknowledge has ended.

The CPU changes the enable bits and three general-purpose output lines one bit at a time, through a bit set/reset command. The pins are modelled as separate input, output and output-enable signals. All handshake inputs are synchronous to the port clock.

Top module: `bidir_strobe_port`

## Requirements
- R1: After reset, rx_full is 0, tx_full_n is 1, irq is 0, bus_oe is 0, gpio_out is 0 and both interrupt enables are 0.
- R2: A rising edge of stb_n (low in one cycle, high in the next) loads bus_in from that same cycle into the receive latch. From the next cycle, rx_full is 1 and cpu_rd_data shows the captured byte.
- R3: A cycle with cpu_rd_en high clears rx_full in the next cycle. If a strobe rising edge falls in the same cycle, the strobe wins and rx_full stays 1.
- R4: A cycle with cpu_wr_en high loads cpu_wr_data into the transmit latch and drives tx_full_n to 0 from the next cycle.
- R5: bus_oe is 1 exactly while ack_n is 0, with no clock delay. bus_out always shows the transmit latch.
- R6: A falling edge of ack_n returns tx_full_n to 1 in the next cycle. If a write falls in the same cycle, the write wins and tx_full_n stays 0.
- R7: A receive does not disturb a pending transmit. A strobe edge leaves bus_out and tx_full_n unchanged.
- R8: A bit command (cpu_bit_en high) writes cpu_bit_val into the bit picked by cpu_bit_sel. Select 6 is the transmit interrupt enable and select 4 is the receive interrupt enable. Selects 0, 1 and 2 are gpio_out[0], [1] and [2]. Selects 3, 5 and 7 change nothing.
- R9: irq is (rx_full AND receive enable) OR (tx_done AND transmit enable). tx_done is set by a rising edge of ack_n and cleared by a CPU write; a write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | Write transmit latch |
| cpu_wr_data | input | 8 | Byte to transmit |
| cpu_rd_en | input | 1 | Read receive latch, clears rx_full |
| cpu_rd_data | output | 8 | Receive latch contents |
| cpu_bit_en | input | 1 | Bit set/reset command strobe |
| cpu_bit_sel | input | 3 | Control bit number |
| cpu_bit_val | input | 1 | Value written to the chosen bit |
| bus_in | input | 8 | Bus pins as seen from outside |
| bus_out | output | 8 | Value driven onto the bus |
| bus_oe | output | 1 | Bus driver enable |
| stb_n | input | 1 | Active-low receive strobe |
| ack_n | input | 1 | Active-low transmit acknowledge |
| rx_full | output | 1 | Receive latch holds unread byte |
| tx_full_n | output | 1 | Low while transmit latch waits |
| irq | output | 1 | Shared interrupt request |
| gpio_out | output | 3 | General-purpose control lines |

## Verification
The assertions assume that stb_n, ack_n and the CPU strobes are already synchronous to clk, and that bus_in is stable in the cycle in which stb_n returns high. They also assume that an ack_n rising edge never shares a cycle with a CPU write, because then the order of the two tx_done updates would matter. The stimulus changes every input one time unit after a clock edge. It holds bus_in across each strobe pulse, and it keeps acknowledge pulses apart from writes, except in the two collision cases that are driven on purpose.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
    localparam int DW     = 8;
    localparam int CTRL_W = 8;
    localparam int SEL_W  = $clog2(CTRL_W);

    typedef logic [DW-1:0] byte_t;

    typedef struct packed {
        byte_t data;
        logic  full;
    } rx_st_t;

    typedef struct packed {
        byte_t data;
        logic  full;
        logic  done;
    } tx_st_t;
endpackage

// File: rtl/bsp_edge_det.sv
module bsp_edge_det #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic hit
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    generate
        if (RISING) begin : g_rise
            assign hit = !prev_q && sig;
        end else begin : g_fall
            assign hit = prev_q && !sig;
        end
    endgenerate
endmodule

// File: rtl/bsp_rx_latch.sv
module bsp_rx_latch
    import bsp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stb_rise,
    input  logic  rd_en,
    input  byte_t bus_in,
    output byte_t data,
    output logic  full
);
    rx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en) st_d.full = 1'b0;
        if (stb_rise) begin
            st_d.data = bus_in;
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data = st_q.data;
    assign full = st_q.full;

    assert_rx_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stb_rise |=> (full && data == $past(bus_in)));

    assert_rd_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !stb_rise) |=> !full);
endmodule

// File: rtl/bsp_tx_latch.sv
module bsp_tx_latch
    import bsp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  byte_t wr_data,
    input  logic  ack_fall,
    input  logic  ack_rise,
    output byte_t data,
    output logic  full,
    output logic  done
);
    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack_fall) st_d.full = 1'b0;
        if (ack_rise) st_d.done = 1'b1;
        if (wr_en) begin
            st_d.data = wr_data;
            st_d.full = 1'b1;
            st_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data = st_q.data;
    assign full = st_q.full;
    assign done = st_q.done;

    assert_wr_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (full && data == $past(wr_data)));

    assert_ack_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fall && !wr_en) |=> !full);

    assert_done_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rise && !wr_en) |=> done);
endmodule

// File: rtl/bsp_ctrl_reg.sv
module bsp_ctrl_reg
    import bsp_pkg::*;
#(
    parameter int GPIO_W     = 3,
    parameter int IE_OUT_BIT = 6,
    parameter int IE_IN_BIT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              bit_val,
    output logic              ie_out,
    output logic              ie_in,
    output logic [GPIO_W-1:0] gpio
);
    typedef struct packed {
        logic              ie_out;
        logic              ie_in;
        logic [GPIO_W-1:0] gpio;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bit_en) begin
            if (bit_sel == SEL_W'(IE_OUT_BIT)) st_d.ie_out = bit_val;
            if (bit_sel == SEL_W'(IE_IN_BIT))  st_d.ie_in  = bit_val;
            for (int i = 0; i < GPIO_W; i++) begin
                if (bit_sel == SEL_W'(i)) st_d.gpio[i] = bit_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ie_out = st_q.ie_out;
    assign ie_in  = st_q.ie_in;
    assign gpio   = st_q.gpio;

    generate
        for (genvar g = 0; g < GPIO_W; g++) begin : g_chk
            assert_gpio_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (bit_en && bit_sel == SEL_W'(g)) |=> (gpio[g] == $past(bit_val)));
        end
    endgenerate

    assert_ie_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(ie_out) && $stable(ie_in) && $stable(gpio)));
endmodule

// File: rtl/bidir_strobe_port.sv
module bidir_strobe_port
    import bsp_pkg::*;
#(
    parameter int GPIO_W     = 3,
    parameter int IE_OUT_BIT = 6,
    parameter int IE_IN_BIT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic [DW-1:0]     cpu_wr_data,
    input  logic              cpu_rd_en,
    output logic [DW-1:0]     cpu_rd_data,
    input  logic              cpu_bit_en,
    input  logic [SEL_W-1:0]  cpu_bit_sel,
    input  logic              cpu_bit_val,
    input  logic [DW-1:0]     bus_in,
    output logic [DW-1:0]     bus_out,
    output logic              bus_oe,
    input  logic              stb_n,
    input  logic              ack_n,
    output logic              rx_full,
    output logic              tx_full_n,
    output logic              irq,
    output logic [GPIO_W-1:0] gpio_out
);
    logic stb_rise, ack_fall, ack_rise;
    logic tx_full, tx_done, ie_out, ie_in;

    bsp_edge_det #(.RISING(1'b1)) u_stb_rise (
        .clk(clk), .rst_n(rst_n), .sig(stb_n), .hit(stb_rise));
    bsp_edge_det #(.RISING(1'b0)) u_ack_fall (
        .clk(clk), .rst_n(rst_n), .sig(ack_n), .hit(ack_fall));
    bsp_edge_det #(.RISING(1'b1)) u_ack_rise (
        .clk(clk), .rst_n(rst_n), .sig(ack_n), .hit(ack_rise));

    bsp_rx_latch u_rx (
        .clk(clk), .rst_n(rst_n), .stb_rise(stb_rise), .rd_en(cpu_rd_en),
        .bus_in(bus_in), .data(cpu_rd_data), .full(rx_full));

    bsp_tx_latch u_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr_en), .wr_data(cpu_wr_data),
        .ack_fall(ack_fall), .ack_rise(ack_rise),
        .data(bus_out), .full(tx_full), .done(tx_done));

    bsp_ctrl_reg #(
        .GPIO_W(GPIO_W), .IE_OUT_BIT(IE_OUT_BIT), .IE_IN_BIT(IE_IN_BIT)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .bit_en(cpu_bit_en), .bit_sel(cpu_bit_sel),
        .bit_val(cpu_bit_val), .ie_out(ie_out), .ie_in(ie_in), .gpio(gpio_out));

    assign tx_full_n = !tx_full;
    assign bus_oe    = !ack_n;
    assign irq       = (rx_full && ie_in) || (tx_done && ie_out);

    assert_rx_keeps_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_rise && !cpu_wr_en && !ack_fall) |=> ($stable(bus_out) && $stable(tx_full_n)));

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_full && !tx_done) |-> !irq);

    assert_reset_state_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!rx_full && tx_full_n && !irq && gpio_out == '0));
endmodule

// File: tb/bidir_strobe_port_tb.sv
module bidir_strobe_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr_en = 1'b0;
    logic [7:0] cpu_wr_data = '0;
    logic       cpu_rd_en = 1'b0;
    logic [7:0] cpu_rd_data;
    logic       cpu_bit_en = 1'b0;
    logic [2:0] cpu_bit_sel = '0;
    logic       cpu_bit_val = 1'b0;
    logic [7:0] bus_in = '0;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic       stb_n = 1'b1;
    logic       ack_n = 1'b1;
    logic       rx_full, tx_full_n, irq;
    logic [2:0] gpio_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic       m_ibf = 0, m_obf = 0, m_txd = 0, m_iei = 0, m_ieo = 0;
    logic [7:0] m_rx = '0, m_tx = '0;
    logic [2:0] m_gpio = '0;

    always #2.5 clk = ~clk;

    bidir_strobe_port u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data), .cpu_bit_en(cpu_bit_en),
        .cpu_bit_sel(cpu_bit_sel), .cpu_bit_val(cpu_bit_val), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .stb_n(stb_n), .ack_n(ack_n),
        .rx_full(rx_full), .tx_full_n(tx_full_n), .irq(irq), .gpio_out(gpio_out));

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_irq();
        return (m_ibf && m_iei) || (m_txd && m_ieo);
    endfunction

    task automatic chk_flags(string req);
        chk({req, " rx_full"}, rx_full, m_ibf);
        chk({req, " tx_full_n"}, tx_full_n, !m_obf);
        chk({req, " irq"}, irq, exp_irq());
        chk({req, " bus_out"}, bus_out, m_tx);
    endtask

    task automatic bitop(logic [2:0] sel, logic val);
        cpu_bit_en = 1'b1; cpu_bit_sel = sel; cpu_bit_val = val;
        tick();
        cpu_bit_en = 1'b0;
        if (sel == 3'd6) m_ieo = val;
        if (sel == 3'd4) m_iei = val;
        if (sel < 3'd3)  m_gpio[sel] = val;
        chk("R8 gpio_out", gpio_out, m_gpio);
        chk("R8 irq", irq, exp_irq());
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 rx_full", rx_full, 0);
        chk("R1 tx_full_n", tx_full_n, 1);
        chk("R1 irq", irq, 0);
        chk("R1 bus_oe", bus_oe, 0);
        chk("R1 gpio_out", gpio_out, 0);

        // R8 sweep of every select with both values
        for (int s = 0; s < 8; s++) begin
            bitop(3'(s), 1'b1);
            bitop(3'(s), 1'b0);
            bitop(3'(s), 1'b1);
        end

        for (int v = 0; v < 256; v++) begin
            logic [7:0] d, r;
            d = 8'(v);
            r = d ^ 8'hA5;
            bitop(3'd4, d[0]);
            bitop(3'd6, d[1]);
            // R4 write
            cpu_wr_en = 1'b1; cpu_wr_data = d;
            tick();
            cpu_wr_en = 1'b0;
            m_tx = d; m_obf = 1; m_txd = 0;
            chk_flags("R4");
            chk("R5 oe idle", bus_oe, 0);
            // R2 strobe, R7 transmit undisturbed
            bus_in = r; stb_n = 1'b0;
            tick();
            stb_n = 1'b1;
            tick();
            m_ibf = 1; m_rx = r;
            bus_in = ~r;
            chk("R2 rd_data", cpu_rd_data, m_rx);
            chk_flags("R7");
            // R5 acknowledge drives bus
            ack_n = 1'b0;
            #1;
            chk("R5 oe", bus_oe, 1);
            chk("R5 bus_out", bus_out, d);
            tick();
            m_obf = 0;
            chk_flags("R6");
            ack_n = 1'b1;
            #1;
            chk("R5 oe release", bus_oe, 0);
            tick();
            m_txd = 1;
            chk_flags("R9 tx done");
            // R3 read
            cpu_rd_en = 1'b1;
            tick();
            cpu_rd_en = 1'b0;
            m_ibf = 0;
            chk_flags("R3");
        end

        // R3 read colliding with strobe edge: strobe wins
        bitop(3'd4, 1'b1);
        bus_in = 8'h3C; stb_n = 1'b0;
        tick();
        stb_n = 1'b1; cpu_rd_en = 1'b1;
        tick();
        cpu_rd_en = 1'b0;
        m_ibf = 1; m_rx = 8'h3C;
        chk("R3 collide rx_full", rx_full, 1);
        chk("R3 collide data", cpu_rd_data, 8'h3C);

        // R6 write colliding with ack fall: write wins
        ack_n = 1'b0; cpu_wr_en = 1'b1; cpu_wr_data = 8'h5A;
        tick();
        cpu_wr_en = 1'b0;
        m_tx = 8'h5A; m_obf = 1; m_txd = 0;
        chk_flags("R6 collide");
        ack_n = 1'b1;
        tick();
        m_txd = 1;
        chk_flags("R9 after collide");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule